// File: doc/BRIEF.md
# Programmable Tick Timer with Duty-Cycle Compare

This block is a timer that produces a periodic or pulse-width-modulated signal from one fast reference clock. A chain of prescalers derives three tick rates: the full reference rate, the reference rate divided by `PRE_DIV`, and the reference rate divided by `PRE_DIV` squared. A two-bit selector picks one of these rates or no tick at all. A 16-bit up-counter advances on each selected tick and wraps after a programmable terminal count. The output rises once the count has passed a programmable threshold, so the threshold sets the duty cycle.

The configuration inputs are a run bit, a polarity bit, the rate selector, the terminal count and the threshold. All of them are plain level inputs that the surrounding register logic holds. Selecting "no tick" while running freezes the count and the output where they are. Selecting a rate again continues from the frozen point. The polarity bit flips the output in every state, and this includes the idle level while the timer is stopped. Each tick is a one-cycle enable pulse in the reference clock domain. No derived clocks are created.

Top module: `pwm_delay_timer`

## Requirements
- R1: While `run` is 0, `wave_out` equals `polarity` (idle level 0, or 1 when `polarity` is 1), and the count is held at 0.
- R2: With `polarity` = 1, `wave_out` is the complement of the value it would have with `polarity` = 0, for the same count and settings.
- R3: With `rate_sel` = 2'b01, the count advances by one on every reference clock cycle while `run` is 1.
- R4: With `rate_sel` = 2'b10, the count advances once every `PRE_DIV` reference cycles. With `rate_sel` = 2'b11, it advances once every `PRE_DIV`² cycles. The prescalers restart from zero when `run` rises, so the first advance comes exactly `PRE_DIV` (or `PRE_DIV`²) cycles after the rise.
- R5: With `rate_sel` = 2'b00 while running, the count and `wave_out` hold their values. After a rate is selected again, counting continues from the held count and does not restart.
- R6: The count runs 0, 1, …, `term_cnt` and then returns to 0 on the next tick, so one period lasts `term_cnt` + 1 ticks. A tick taken at a count at or above `term_cnt` returns the count to 0.
- R7: With `polarity` = 0, `wave_out` is 1 exactly when the count is strictly greater than `high_at`. The high time is therefore `term_cnt` − `high_at` ticks per period. When `high_at` ≥ `term_cnt`, the output stays 0 for the whole period.
- R8: A rising edge on `run` starts a new period from count 0.
- R9: A synchronous reset clears the count and the prescalers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timer enable; 0 stops and clears the count |
| polarity | input | 1 | Inverts `wave_out`, including the idle level |
| rate_sel | input | 2 | Tick source: 00 none, 01 reference, 10 ÷PRE_DIV, 11 ÷PRE_DIV² |
| term_cnt | input | 16 | Terminal count; the period is term_cnt + 1 ticks |
| high_at | input | 16 | Threshold; output is active while the count is above it |
| wave_out | output | 1 | Timer output |

## Verification
The assertions assume that the configuration inputs change only between clock edges and never during reset. They also assume that `run` is the only control that clears the count, so a change to `term_cnt` below the current count is covered only by the wrap-at-or-above rule. The stimulus drives every input on the falling edge. Before it loads a new set of settings, it drops `run` for one cycle, so each vector starts from count 0 with fresh prescalers. The bench shortens `PRE_DIV` to 4 so that the slowest rate completes several ticks within the run. The pause test changes only `rate_sel` while running, which keeps the frozen count observable through `wave_out`.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    localparam int TMR_W     = 16;
    localparam int PRE_STAGES = 2;

    typedef enum logic [1:0] {
        RATE_NONE = 2'b00,
        RATE_REF  = 2'b01,
        RATE_MID  = 2'b10,
        RATE_SLOW = 2'b11
    } rate_sel_e;

    typedef struct packed {
        logic             run;
        logic             polarity;
        rate_sel_e        rate;
        logic [TMR_W-1:0] term_cnt;
        logic [TMR_W-1:0] high_at;
    } tmr_cfg_t;

    typedef struct packed {
        logic             tick;
        logic [TMR_W-1:0] count;
    } tmr_state_t;

    function automatic logic active_phase(input logic [TMR_W-1:0] count,
                                          input logic [TMR_W-1:0] high_at);
        return count > high_at;
    endfunction

    function automatic logic [TMR_W-1:0] next_count(input logic [TMR_W-1:0] count,
                                                    input logic [TMR_W-1:0] term_cnt);
        if (count >= term_cnt) begin
            return '0;
        end
        return count + 1'b1;
    endfunction

endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
    parameter int DIV    = 1024,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [STAGES-1:0] stage_tick
);
    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [STAGES-1:0] advance;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [DIV_W-1:0] div_q;

        if (g == 0) begin : g_first
            assign advance[g] = 1'b1;
        end else begin : g_next
            assign advance[g] = stage_tick[g-1];
        end

        assign stage_tick[g] = run && advance[g] && (div_q == LAST);

        always_ff @(posedge clk) begin
            if (rst || !run) begin
                div_q <= '0;
            end else if (advance[g]) begin
                if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pdt_tick_select.sv
module pdt_tick_select
    import pdt_pkg::*;
(
    input  rate_sel_e                rate,
    input  logic                     run,
    input  logic [PRE_STAGES-1:0]    stage_tick,
    output logic                     tick
);
    always_comb begin
        tick = 1'b0;
        unique case (rate)
            RATE_NONE: tick = 1'b0;
            RATE_REF:  tick = run;
            RATE_MID:  tick = stage_tick[0];
            RATE_SLOW: tick = stage_tick[1];
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/pdt_period_counter.sv
module pdt_period_counter
    import pdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [TMR_W-1:0] term_cnt,
    output tmr_state_t       state
);
    logic [TMR_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= next_count(count_q, term_cnt);
        end
    end

    always_comb begin
        state.tick  = tick;
        state.count = count_q;
    end

endmodule

// File: rtl/pdt_wave_gen.sv
module pdt_wave_gen
    import pdt_pkg::*;
(
    input  tmr_cfg_t   cfg,
    input  tmr_state_t state,
    output logic       wave
);
    logic raw;

    always_comb begin
        raw  = cfg.run && active_phase(state.count, cfg.high_at);
        wave = raw ^ cfg.polarity;
    end

endmodule

// File: rtl/pwm_delay_timer.sv
module pwm_delay_timer
    import pdt_pkg::*;
#(
    parameter int PRE_DIV = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             polarity,
    input  logic [1:0]       rate_sel,
    input  logic [TMR_W-1:0] term_cnt,
    input  logic [TMR_W-1:0] high_at,
    output logic             wave_out
);
    tmr_cfg_t              cfg;
    tmr_state_t            state;
    logic [PRE_STAGES-1:0] stage_tick;
    logic                  tick;

    always_comb begin
        cfg.run      = run;
        cfg.polarity = polarity;
        cfg.rate     = rate_sel_e'(rate_sel);
        cfg.term_cnt = term_cnt;
        cfg.high_at  = high_at;
    end

    pdt_prescaler #(
        .DIV    (PRE_DIV),
        .STAGES (PRE_STAGES)
    ) u_pre (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg.run),
        .stage_tick (stage_tick)
    );

    pdt_tick_select u_sel (
        .rate       (cfg.rate),
        .run        (cfg.run),
        .stage_tick (stage_tick),
        .tick       (tick)
    );

    pdt_period_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg.run),
        .tick     (tick),
        .term_cnt (cfg.term_cnt),
        .state    (state)
    );

    pdt_wave_gen u_wave (
        .cfg   (cfg),
        .state (state),
        .wave  (wave_out)
    );

endmodule

// File: rtl/pdt_checker.sv
module pdt_checker
    import pdt_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  run,
    input logic                  polarity,
    input logic [1:0]            rate_sel,
    input logic [TMR_W-1:0]      term_cnt,
    input logic                  wave_out,
    input logic [TMR_W-1:0]      count,
    input logic                  tick,
    input logic [PRE_STAGES-1:0] stage_tick
);
    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (wave_out == polarity));

    // R1
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count == '0));

    // R3
    ref_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && rate_sel == 2'b01 && count < term_cnt) |=> (count == $past(count) + 1'b1));

    // R4
    slow_nested_chk: assert property (@(posedge clk) disable iff (rst)
        stage_tick[1] |-> stage_tick[0]);

    // R5
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && rate_sel == 2'b00) |=> $stable(count));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count >= term_cnt) |=> (count == '0));

    // R8
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (count == '0));

endmodule

bind pwm_delay_timer pdt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .polarity   (polarity),
    .rate_sel   (rate_sel),
    .term_cnt   (term_cnt),
    .wave_out   (wave_out),
    .count      (state.count),
    .tick       (tick),
    .stage_tick (stage_tick)
);

// File: tb/pwm_delay_timer_test.sv
module pwm_delay_timer_test;
    localparam int DIV = 4;
    localparam int NV  = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        polarity = 1'b0;
    logic [1:0]  rate_sel = 2'b01;
    logic [15:0] term_cnt = '0;
    logic [15:0] high_at = '0;
    logic        wave_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm_delay_timer #(.PRE_DIV(DIV)) uut (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .polarity (polarity),
        .rate_sel (rate_sel),
        .term_cnt (term_cnt),
        .high_at  (high_at),
        .wave_out (wave_out)
    );

    // {rate 2, term 16, high_at 16, polarity 1, cycles 16, expected 1}
    localparam logic [51:0] VEC [NV] = '{
        {2'b01, 16'd9, 16'd4,  1'b0, 16'd3,  1'b0},  // R3 below threshold
        {2'b01, 16'd9, 16'd4,  1'b0, 16'd5,  1'b1},  // R3 R7 above threshold
        {2'b01, 16'd9, 16'd4,  1'b0, 16'd10, 1'b0},  // R6 wrapped to 0
        {2'b01, 16'd9, 16'd4,  1'b0, 16'd9,  1'b1},  // R6 at terminal count
        {2'b01, 16'd9, 16'd4,  1'b1, 16'd9,  1'b0},  // R2 inverted
        {2'b10, 16'd5, 16'd2,  1'b0, 16'd7,  1'b0},  // R4 mid rate, count 1
        {2'b10, 16'd5, 16'd2,  1'b0, 16'd12, 1'b1},  // R4 mid rate, count 3
        {2'b11, 16'd3, 16'd1,  1'b0, 16'd15, 1'b0},  // R4 slow rate, count 0
        {2'b11, 16'd3, 16'd1,  1'b0, 16'd32, 1'b1},  // R4 slow rate, count 2
        {2'b01, 16'd9, 16'd12, 1'b0, 16'd9,  1'b0},  // R7 threshold beyond term
        {2'b01, 16'd0, 16'd0,  1'b0, 16'd5,  1'b0},  // R6 R7 one-tick period
        {2'b00, 16'd9, 16'd0,  1'b1, 16'd20, 1'b1}   // R5 no tick from start
    };

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (wave_out !== exp) begin
            fails++;
            $display("FAIL %s: wave_out=%b expected=%b", req, wave_out, exp);
        end
    endtask

    task automatic restart(input logic [1:0] r, input logic [15:0] t,
                           input logic [15:0] h, input logic p);
        run = 1'b0;
        step(1);
        rate_sel = r;
        term_cnt = t;
        high_at  = h;
        polarity = p;
        run = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: expired, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi;
        @(negedge clk);
        step(2);
        check("R9 reset level", 1'b0);
        rst = 1'b0;
        step(1);

        polarity = 1'b1;
        step(3);
        check("R1 idle inverted", 1'b1);
        polarity = 1'b0;
        step(1);
        check("R1 idle plain", 1'b0);

        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][51:50], VEC[v][49:34], VEC[v][33:18], VEC[v][17]);
            step(int'(VEC[v][16:1]));
            check($sformatf("R3/R4/R6/R7 vector %0d", v), VEC[v][0]);
        end

        // R5: freeze at count 5, hold, then resume from 5
        restart(2'b01, 16'd9, 16'd4, 1'b0);
        step(5);
        check("R5 before pause", 1'b1);
        rate_sel = 2'b00;
        step(7);
        check("R5 held during pause", 1'b1);
        rate_sel = 2'b01;
        step(4);
        check("R5 resumed count 9", 1'b1);
        step(1);
        check("R5 resumed wrap", 1'b0);

        // R8: restart after disable begins at count 0
        restart(2'b01, 16'd9, 16'd4, 1'b0);
        step(7);
        check("R8 before stop", 1'b1);
        restart(2'b01, 16'd9, 16'd4, 1'b0);
        check("R8 fresh start count 0", 1'b0);
        step(5);
        check("R8 count 5 after restart", 1'b1);

        // R7: duty over one full period
        restart(2'b01, 16'd9, 16'd4, 1'b0);
        hi = 0;
        for (int c = 0; c < 10; c++) begin
            if (wave_out) hi++;
            step(1);
        end
        checks++;
        if (hi != 5) begin
            fails++;
            $display("FAIL R7 high ticks: actual=%0d expected=5", hi);
        end

        // R7: threshold equal to terminal count never high
        restart(2'b01, 16'd6, 16'd6, 1'b0);
        hi = 0;
        for (int c = 0; c < 14; c++) begin
            if (wave_out) hi++;
            step(1);
        end
        checks++;
        if (hi != 0) begin
            fails++;
            $display("FAIL R7 equal threshold: actual=%0d expected=0", hi);
        end

        // R9: reset mid-run clears count
        restart(2'b01, 16'd9, 16'd4, 1'b0);
        step(7);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        check("R9 count cleared by reset", 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule